// File: doc/BRIEF.md
# Dual DAC Double-Buffered Loader

This block is the register front end for a pair of digital-to-analog converter channels. A host writes each channel's code as two bytes into holding registers, and the block moves the held values to the latched output codes that feed the converters. A static mode input picks when that move happens. In per-channel mode, a channel's output follows as soon as its high byte is written. In paired mode, writes only fill the holding registers. A read strobe aimed at any converter register then moves both channels to their outputs in the same cycle, so the two analog outputs change together.

Codes are held left-justified in a 16-bit word. With the default 12-bit code width, the output code is the upper twelve bits of the word and the lowest four bits are dropped. A separate byte-wide register holds a 2-bit output range selector for each channel. The analog conversion itself lies outside the block. Its outputs are the latched codes and the range selectors.

Top module: `dac_pair_loader`

## Requirements
- R1: After reset, both output codes and all holding bytes are zero, and both range selectors hold code 2.
- R2: Channel n's low byte is at byte address 4+2n and its high byte is at 5+2n. A byte write (`bus_word`=0) takes its data from `bus_wdata[7:0]`. Writes to any other address leave the codes unchanged.
- R3: With `sim_mode`=0, a write to a channel's high byte loads that channel's output, on the following clock edge, from the new high byte and the stored low byte. The other channel's output does not change.
- R4: Writing only a low byte leaves the output unchanged in either mode. A later high-byte write uses the stored low byte.
- R5: A word write (`bus_word`=1) to either address of a channel (address bit 0 is ignored) stores `bus_wdata[7:0]` as the low byte and `bus_wdata[15:8]` as the high byte in one cycle. This write counts as a high-byte write for R3.
- R6: With `sim_mode`=1, no write changes either output code.
- R7: With `sim_mode`=1, a `bus_rd` strobe to any address from 4 to 7 moves both holding words to both outputs on the next edge. A read to any other address, or any read with `sim_mode`=0, changes no output.
- R8: The output code is bits 15 down to 16-CODE_W of the held word {high, low}. The lower bits have no effect on the output.
- R9: A byte or word write to address 10 sets channel 0's range from `bus_wdata[5:4]` and channel 1's range from `bus_wdata[7:6]`. The other data bits are ignored and the codes do not change. Range codes: 0 = ±5 V, 1 = ±10 V, 2 = 0 to 5 V, 3 = 0 to 10 V. Writes to other addresses leave the ranges unchanged.
- R10: In paired mode, a read and a write in the same cycle move the holding words as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (update trigger in paired mode) |
| bus_addr | input | 4 | Byte address |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| sim_mode | input | 1 | 0 = per-channel update, 1 = paired update on read |
| dac0_code | output | CODE_W | Latched code, channel 0 |
| dac1_code | output | CODE_W | Latched code, channel 1 |
| dac0_range | output | 2 | Range selector, channel 0 |
| dac1_range | output | 2 | Range selector, channel 1 |

## Verification
On every cycle, the assertions check four things. Each output code holds steady unless an update event was decoded for it. A per-channel update leaves the other channel untouched. Writes in paired mode never move an output, and the range selectors change only on a write to their address. They also check that a paired transfer delivers the previous cycle's holding words to both outputs, and that a word write in per-channel mode appears on the output truncated to its upper bits. The bench scenarios cover the rest. These are the reset state, the byte ordering that builds a code from a stored low byte, the truncation of the low nibble, the range field positions, reads that must do nothing, and the ordering of a read and a write in the same cycle.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;

  localparam int NUM_CH    = 2;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int RANGE_W   = 2;
  localparam int RANGE_LSB = 4;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [RANGE_W-1:0] range_t;

  typedef enum logic [RANGE_W-1:0] {
    RNG_BIP_5  = 2'd0,
    RNG_BIP_10 = 2'd1,
    RNG_UNI_5  = 2'd2,
    RNG_UNI_10 = 2'd3
  } range_code_e;

  // Build the left-justified holding word from its two bytes.
  function automatic word_t join_bytes(input byte_t hi, input byte_t lo);
    return {hi, lo};
  endfunction

  // Select the next value of a holding byte.
  function automatic byte_t pick_byte(input logic we, input byte_t fresh, input byte_t held);
    return we ? fresh : held;
  endfunction

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_pair_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_word,
  input  logic [WORD_W-1:0]            bus_wdata,
  input  logic                         sim_mode,
  output logic [NUM_CH-1:0]            lo_we,
  output logic [NUM_CH-1:0]            hi_we,
  output byte_t                        lo_byte,
  output byte_t                        hi_byte,
  output logic                         range_we,
  output logic [RANGE_W*NUM_CH-1:0]    range_bits,
  output logic [NUM_CH-1:0]            indiv_upd,
  output logic                         xfer_all
);

  logic [NUM_CH-1:0] pair_hit;

  // Byte lanes: a word carries both bytes, a byte access always uses lane 0.
  assign lo_byte    = bus_wdata[BYTE_W-1:0];
  assign hi_byte    = bus_word ? bus_wdata[WORD_W-1:BYTE_W] : bus_wdata[BYTE_W-1:0];
  assign range_bits = bus_wdata[RANGE_LSB +: RANGE_W*NUM_CH];
  assign range_we   = bus_wr && (bus_addr == RANGE_ADDR[ADDR_W-1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int PAIR_IDX = (DAC_BASE + 2*c) / 2;
    assign pair_hit[c]  = (bus_addr[ADDR_W-1:1] == PAIR_IDX[ADDR_W-2:0]);
    assign lo_we[c]     = bus_wr && pair_hit[c] && (bus_word || !bus_addr[0]);
    assign hi_we[c]     = bus_wr && pair_hit[c] && (bus_word ||  bus_addr[0]);
    assign indiv_upd[c] = hi_we[c] && !sim_mode;
  end

  assign xfer_all = bus_rd && sim_mode && (|pair_hit);

endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_pair_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  byte_t             lo_byte,
  input  byte_t             hi_byte,
  input  logic              indiv_upd,
  input  logic              xfer_all,
  output word_t             hold_word,
  output logic [CODE_W-1:0] code
);

  byte_t hold_lo, hold_hi;
  byte_t next_lo, next_hi;
  word_t next_word;

  assign next_lo   = pick_byte(lo_we, lo_byte, hold_lo);
  assign next_hi   = pick_byte(hi_we, hi_byte, hold_hi);
  assign next_word = join_bytes(next_hi, next_lo);
  assign hold_word = join_bytes(hold_hi, hold_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_lo <= '0;
      hold_hi <= '0;
    end else begin
      hold_lo <= next_lo;
      hold_hi <= next_hi;
    end
  end

  // Paired transfer takes the word held before this cycle's write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (xfer_all) begin
      code <= hold_word[WORD_W-1 -: CODE_W];
    end else if (indiv_upd) begin
      code <= next_word[WORD_W-1 -: CODE_W];
    end
  end

endmodule

// File: rtl/dac_range_reg.sv
module dac_range_reg
  import dac_pair_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      range_we,
  input  logic [RANGE_W*NUM_CH-1:0] range_bits,
  output logic [RANGE_W*NUM_CH-1:0] range_q
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        range_q[RANGE_W*c +: RANGE_W] <= RNG_UNI_5;
      end else if (range_we) begin
        range_q[RANGE_W*c +: RANGE_W] <= range_bits[RANGE_W*c +: RANGE_W];
      end
    end
  end

endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader
  import dac_pair_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_word,
  input  logic [15:0]       bus_wdata,
  input  logic              sim_mode,
  output logic [CODE_W-1:0] dac0_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic [1:0]        dac0_range,
  output logic [1:0]        dac1_range
);

  logic [NUM_CH-1:0]               lo_we, hi_we, indiv_upd;
  byte_t                           lo_byte, hi_byte;
  logic                            range_we, xfer_all;
  logic [RANGE_W*NUM_CH-1:0]       range_bits, range_q;
  logic [NUM_CH-1:0][WORD_W-1:0]   hold_word;
  logic [NUM_CH-1:0][CODE_W-1:0]   code_q;

  dac_bus_decode #(
    .ADDR_W(ADDR_W), .DAC_BASE(DAC_BASE), .RANGE_ADDR(RANGE_ADDR)
  ) u_decode (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .sim_mode(sim_mode),
    .lo_we(lo_we), .hi_we(hi_we), .lo_byte(lo_byte), .hi_byte(hi_byte),
    .range_we(range_we), .range_bits(range_bits),
    .indiv_upd(indiv_upd), .xfer_all(xfer_all)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dac_channel #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .lo_we(lo_we[c]), .hi_we(hi_we[c]),
      .lo_byte(lo_byte), .hi_byte(hi_byte),
      .indiv_upd(indiv_upd[c]), .xfer_all(xfer_all),
      .hold_word(hold_word[c]), .code(code_q[c])
    );
  end

  dac_range_reg u_range (
    .clk(clk), .rst_n(rst_n),
    .range_we(range_we), .range_bits(range_bits), .range_q(range_q)
  );

  assign dac0_code  = code_q[0];
  assign dac1_code  = code_q[1];
  assign dac0_range = range_q[1:0];
  assign dac1_range = range_q[3:2];

endmodule

// File: rtl/dac_pair_loader_chk.sv
module dac_pair_loader_chk
  import dac_pair_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_wr,
  input logic                            bus_rd,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic                            bus_word,
  input logic [15:0]                     bus_wdata,
  input logic                            sim_mode,
  input logic [CODE_W-1:0]               dac0_code,
  input logic [CODE_W-1:0]               dac1_code,
  input logic [1:0]                      dac0_range,
  input logic [1:0]                      dac1_range,
  input logic [NUM_CH-1:0]               ev_upd,
  input logic                            ev_xfer,
  input logic [NUM_CH-1:0][WORD_W-1:0]   hold_w
);

  localparam int CH1_PAIR = DAC_BASE / 2 + 1;

  assert_code0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_upd[0] || ev_xfer) |=> $stable(dac0_code));

  assert_code1_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_upd[1] || ev_xfer) |=> $stable(dac1_code));

  assert_other_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd[0] |=> $stable(dac1_code));

  assert_paired_write_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_mode && bus_wr && !bus_rd) |=> ($stable(dac0_code) && $stable(dac1_code)));

  assert_paired_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |=> (dac0_code == $past(hold_w[0][WORD_W-1 -: CODE_W]) &&
                 dac1_code == $past(hold_w[1][WORD_W-1 -: CODE_W])));

  assert_word_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sim_mode && bus_wr && bus_word && (bus_addr[ADDR_W-1:1] == CH1_PAIR[ADDR_W-2:0]))
      |=> dac1_code == $past(bus_wdata[15 -: CODE_W]));

  assert_range_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == RANGE_ADDR[ADDR_W-1:0]) |=> ($stable(dac0_range) && $stable(dac1_range)));

endmodule

bind dac_pair_loader dac_pair_loader_chk #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DAC_BASE(DAC_BASE), .RANGE_ADDR(RANGE_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_word(bus_word), .bus_wdata(bus_wdata),
  .sim_mode(sim_mode), .dac0_code(dac0_code), .dac1_code(dac1_code),
  .dac0_range(dac0_range), .dac1_range(dac1_range),
  .ev_upd(indiv_upd), .ev_xfer(xfer_all), .hold_w(hold_word)
);

// File: tb/dac_pair_loader_tb.sv
module dac_pair_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic              bus_word = 1'b0;
  logic [15:0]       bus_wdata = '0;
  logic              sim_mode = 1'b0;
  logic [CODE_W-1:0] dac0_code, dac1_code;
  logic [1:0]        dac0_range, dac1_range;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0]        m_lo [2];
  logic [7:0]        m_hi [2];
  logic [CODE_W-1:0] m_code [2];
  logic [1:0]        m_rng [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_pair_loader dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .sim_mode(sim_mode), .dac0_code(dac0_code), .dac1_code(dac1_code),
    .dac0_range(dac0_range), .dac1_range(dac1_range)
  );

  // R8: the code is the top CODE_W bits of {high, low}.
  function automatic logic [CODE_W-1:0] code_of(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] w;
    w = {hi, lo};
    return CODE_W'(w >> (16 - CODE_W));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " code0"},  int'(dac0_code),  int'(m_code[0]));
    check({req, " code1"},  int'(dac1_code),  int'(m_code[1]));
    check({req, " range0"}, int'(dac0_range), int'(m_rng[0]));
    check({req, " range1"}, int'(dac1_range), int'(m_rng[1]));
  endtask

  // Reference behaviour written from the requirements.
  task automatic model_step(input bit wr, input bit rd, input logic [3:0] a,
                            input bit w, input logic [15:0] d);
    logic [7:0] o_lo [2];
    logic [7:0] o_hi [2];
    int  ch;
    bit  hiw;
    o_lo = m_lo;
    o_hi = m_hi;
    if (rd && sim_mode && a >= 4 && a <= 7) begin
      m_code[0] = code_of(o_hi[0], o_lo[0]);
      m_code[1] = code_of(o_hi[1], o_lo[1]);
    end
    if (wr && a >= 4 && a <= 7) begin
      ch  = (int'(a) - 4) / 2;
      hiw = 1'b0;
      if (w) begin
        m_lo[ch] = d[7:0]; m_hi[ch] = d[15:8]; hiw = 1'b1;
      end else if (!a[0]) begin
        m_lo[ch] = d[7:0];
      end else begin
        m_hi[ch] = d[7:0]; hiw = 1'b1;
      end
      if (hiw && !sim_mode) m_code[ch] = code_of(m_hi[ch], m_lo[ch]);
    end
    if (wr && a == 4'd10) begin
      m_rng[0] = d[5:4];
      m_rng[1] = d[7:6];
    end
  endtask

  task automatic bus_op(input bit wr, input bit rd, input logic [3:0] a,
                        input bit w, input logic [15:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_word = w; bus_wdata = d;
    model_step(wr, rd, a, w, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_word = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    sim_mode = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    for (int c = 0; c < 2; c++) begin
      m_lo[c] = '0; m_hi[c] = '0; m_code[c] = '0; m_rng[c] = 2'd2;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2/R4: a low byte alone does nothing to the output
    bus_op(1, 0, 4'd4, 0, 16'h0034);
    check("R4 low only", int'(dac0_code), 0);
    // R3/R2: high byte loads the code built from the stored low byte
    bus_op(1, 0, 4'd5, 0, 16'h00AB);
    check("R3 high byte", int'(dac0_code), 'hAB3);
    check("R3 other chan", int'(dac1_code), 0);
    // R2: the upper data lane is ignored on a byte access
    bus_op(1, 0, 4'd7, 0, 16'hFF21);
    check("R2 byte lane", int'(dac1_code), 'h210);
    // R5: word write, bit 0 of the address ignored
    bus_op(1, 0, 4'd7, 1, 16'h5A7F);
    check("R5 word write", int'(dac1_code), 'h5A7);
    // R8: the low nibble has no effect
    bus_op(1, 0, 4'd4, 1, 16'h123F);
    check("R8 nibble a", int'(dac0_code), 'h123);
    bus_op(1, 0, 4'd4, 1, 16'h1230);
    check("R8 nibble b", int'(dac0_code), 'h123);
    // R2: an address outside the map changes nothing
    bus_op(1, 0, 4'd3, 1, 16'hFFFF);
    check_all("R2 unmapped");
    // R7: a read in per-channel mode does nothing
    bus_op(0, 1, 4'd5, 0, 16'h0);
    check_all("R7 read indiv");

    // R6: writes in paired mode only fill the holding registers
    set_mode(1);
    bus_op(1, 0, 4'd4, 1, 16'hFFF0);
    bus_op(1, 0, 4'd6, 0, 16'h0099);
    bus_op(1, 0, 4'd7, 0, 16'h0088);
    check("R6 code0 held", int'(dac0_code), 'h123);
    check("R6 code1 held", int'(dac1_code), 'h5A7);
    // R7: a read outside the converter registers moves nothing
    bus_op(0, 1, 4'd10, 0, 16'h0);
    check("R7 read other", int'(dac0_code), 'h123);
    // R7: a read of any converter register moves both channels
    bus_op(0, 1, 4'd6, 0, 16'h0);
    check("R7 xfer code0", int'(dac0_code), 'hFFF);
    check("R7 xfer code1", int'(dac1_code), 'h889);
    // R10: a read and a write together move the old holding words
    bus_op(1, 1, 4'd4, 1, 16'h4444);
    check("R10 same cycle", int'(dac0_code), 'hFFF);
    bus_op(0, 1, 4'd4, 0, 16'h0);
    check("R10 next read", int'(dac0_code), 'h444);

    // R9: range fields at bits 5:4 and 7:6, codes untouched
    bus_op(1, 0, 4'd10, 0, 16'hFFD6);
    check("R9 range0", int'(dac0_range), 1);
    check("R9 range1", int'(dac1_range), 3);
    check("R9 code0 kept", int'(dac0_code), 'h444);
    bus_op(1, 0, 4'd11, 1, 16'h0000);
    check_all("R9 other addr");

    set_mode(0);
    for (int i = 0; i < 1500; i++) begin
      int         kind;
      logic [3:0] a;
      logic [15:0] d;
      kind = int'($urandom % 8);
      a    = ($urandom % 4 != 0) ? 4'(4 + $urandom % 4) : 4'($urandom % 16);
      d    = 16'($urandom);
      case (kind)
        0, 1, 2: bus_op(1, 0, a, 0, d);
        3:       bus_op(1, 0, a, 1, d);
        4, 5:    bus_op(0, 1, a, 0, d);
        6:       set_mode(~sim_mode);
        default: bus_op(1, 1, a, $urandom % 2 == 1, d);
      endcase
      @(negedge clk);
      check_all("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule